// File: doc/BRIEF.md
# NEC Infrared Frame Transmitter

This block turns a 32-bit remote-control message into an NEC-coded infrared pulse train on a single transmit pin. Software writes the message word through a write strobe. The word sits in a one-deep holding register, with a busy flag raised, until the frame engine is free to take it. The engine then copies the word into its own shift register and clears busy at once, without waiting for the frame to finish. It then plays the leader, the 32 data bits (least significant bit first) and the closing mark. During marks the output toggles on every carrier tick, and during spaces it stays low.

All timing is counted in carrier ticks. One tick is one half-period of the carrier, so the output toggles once per tick. Ticks are grouped into units of nominally 562 µs. The message word holds, from the low byte up: address, inverted address, command and inverted command. The block does not build this word. Software assembles it.

If software writes the same word again while a 108 ms window is still open, the block sends the short NEC repeat code instead of a full frame. The window is timed from the start of the most recent full frame or repeat.

Top module: `nec_ir_tx`

## Requirements
- R1: A cycle with `wr_en_i` high stores `wr_data_i` in the holding register, and `busy_o` reads 1 in the following cycle.
- R2: When the engine is idle, a pending word is taken one cycle after it is written, and `busy_o` reads 0 in the cycle after that. The flag does not stay high for the length of the frame.
- R3: A word written while a frame is being sent keeps `busy_o` high until that frame's closing mark ends, and only then starts. If several words are written during one frame, only the last of them is sent.
- R4: A full frame is a 16-unit mark, an 8-unit space, 32 bits sent from bit 0 upward, and a 1-unit closing mark. Each bit is a 1-unit mark followed by a 1-unit space for a 0 or a 3-unit space for a 1.
- R5: During a mark, `txd_o` inverts on every carrier tick, and the first tick of each mark drives it to 1. During spaces and while idle it is 0. It changes only in cycles after a tick, and UNIT_TICKS must be even so that every mark ends low.
- R6: A word equal to the last word sent, taken while the window is open, produces a repeat code: a 16-unit mark, a 4-unit space and a 1-unit closing mark.
- R7: The window restarts at the start of every full frame and every repeat, and stays open for WINDOW_UNITS units (192 by default, about 108 ms). A word taken after the window has closed, or any word that differs from the last one, produces a full frame.
- R8: After reset `txd_o` and `busy_o` are 0 and no window is open, so the first word after reset is always sent as a full frame, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the message word |
| wr_data_i | input | 32 | Message word: address, ~address, command, ~command from the low byte up |
| busy_o | output | 1 | A written word is waiting in the holding register |
| carrier_tick_i | input | 1 | One-cycle pulse per carrier half-period |
| txd_o | output | 1 | Modulated infrared drive, high while the LED is lit |

## Verification
The bench builds the block with UNIT_TICKS at 2 and the default 192-unit window, and pulses the carrier tick every second clock. At that scale a full frame lasts a few hundred ticks, and the window expires within about a thousand clocks. This lets one run cover a repeat queued during a full frame, a repeat chained from a previous repeat after the first frame's window has already passed, an expired window, and the case where the last of several writes wins. The modulated output is compared tick by tick against a frame model built from the message bits.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

    // Protocol lengths in units of about 562 us
    localparam int LEAD_MARK_U  = 16;
    localparam int LEAD_SPACE_U = 8;
    localparam int REP_SPACE_U  = 4;
    localparam int BIT_MARK_U   = 1;
    localparam int ZERO_SPACE_U = 1;
    localparam int ONE_SPACE_U  = 3;
    localparam int STOP_MARK_U  = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD_MARK,
        PH_LEAD_SPACE,
        PH_BIT_MARK,
        PH_BIT_SPACE,
        PH_STOP_MARK
    } phase_e;

    function automatic logic is_mark(phase_e p);
        return (p == PH_LEAD_MARK) || (p == PH_BIT_MARK) || (p == PH_STOP_MARK);
    endfunction

endpackage

// File: rtl/nec_tx_hold.sv
module nec_tx_hold #(
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [MSG_W-1:0] data_i,
    input  logic             take_i,
    output logic             busy_o,
    output logic [MSG_W-1:0] word_o
);

    typedef struct packed {
        logic             pend;
        logic [MSG_W-1:0] word;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take_i) begin
            s_d.pend = 1'b0;
        end
        if (wr_i) begin
            s_d.pend = 1'b1;
            s_d.word = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.pend;
    assign word_o = s_q.word;

    p_busy_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> busy_o)
        else $error("busy not raised after write");

    p_busy_drops_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !wr_i) |=> !busy_o)
        else $error("busy still set after transfer");

endmodule

// File: rtl/nec_tx_window.sv
module nec_tx_window #(
    parameter int LIMIT_TICKS = 8064
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic open_o
);

    localparam int CW = $clog2(LIMIT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT_TICKS);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } win_t;

    win_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (tick_i && (s_q.cnt < LIMIT_C)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open_o = s_q.armed && (s_q.cnt < LIMIT_C);

    p_restart_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> open_o)
        else $error("window not open after restart");

    p_closed_stays_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && !restart_i) |=> !open_o)
        else $error("window reopened without a frame start");

endmodule

// File: rtl/nec_tx_seq.sv
module nec_tx_seq
    import nec_tx_pkg::*;
#(
    parameter int MSG_W      = 32,
    parameter int UNIT_TICKS = 42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pend_i,
    input  logic [MSG_W-1:0] word_i,
    input  logic             win_open_i,
    output logic             take_o,
    output logic             rep_start_o,
    output logic             txd_o
);

    localparam int LW = $clog2(LEAD_MARK_U * UNIT_TICKS + 1);
    localparam int BW = $clog2(MSG_W);
    localparam logic [LW-1:0] T_LEAD_MARK  = LW'(LEAD_MARK_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_LEAD_SPACE = LW'(LEAD_SPACE_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_REP_SPACE  = LW'(REP_SPACE_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_BIT_MARK   = LW'(BIT_MARK_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_ZERO_SPACE = LW'(ZERO_SPACE_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_ONE_SPACE  = LW'(ONE_SPACE_U * UNIT_TICKS);
    localparam logic [LW-1:0] T_STOP_MARK  = LW'(STOP_MARK_U * UNIT_TICKS);
    localparam logic [BW-1:0] LAST_BIT     = BW'(MSG_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic             rep;
        logic [MSG_W-1:0] shift;
        logic [MSG_W-1:0] last;
        logic             last_valid;
        logic [BW-1:0]    bit_idx;
        logic [LW-1:0]    left;
        logic             txd;
    } seq_t;

    seq_t s_d, s_q;
    logic take;
    logic rep_now;

    assign take    = (s_q.phase == PH_IDLE) && pend_i;
    assign rep_now = s_q.last_valid && (word_i == s_q.last) && win_open_i;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.phase      = PH_LEAD_MARK;
            s_d.rep        = rep_now;
            s_d.shift      = word_i;
            s_d.last       = word_i;
            s_d.last_valid = 1'b1;
            s_d.bit_idx    = '0;
            s_d.left       = T_LEAD_MARK;
        end else if (tick_i && (s_q.phase != PH_IDLE)) begin
            s_d.txd = is_mark(s_q.phase) ? ~s_q.txd : 1'b0;
            if (s_q.left > 1) begin
                s_d.left = s_q.left - 1'b1;
            end else begin
                unique case (s_q.phase)
                    PH_LEAD_MARK: begin
                        s_d.phase = PH_LEAD_SPACE;
                        s_d.left  = s_q.rep ? T_REP_SPACE : T_LEAD_SPACE;
                    end
                    PH_LEAD_SPACE: begin
                        if (s_q.rep) begin
                            s_d.phase = PH_STOP_MARK;
                            s_d.left  = T_STOP_MARK;
                        end else begin
                            s_d.phase = PH_BIT_MARK;
                            s_d.left  = T_BIT_MARK;
                        end
                    end
                    PH_BIT_MARK: begin
                        s_d.phase = PH_BIT_SPACE;
                        s_d.left  = s_q.shift[0] ? T_ONE_SPACE : T_ZERO_SPACE;
                    end
                    PH_BIT_SPACE: begin
                        s_d.shift = s_q.shift >> 1;
                        if (s_q.bit_idx == LAST_BIT) begin
                            s_d.phase = PH_STOP_MARK;
                            s_d.left  = T_STOP_MARK;
                        end else begin
                            s_d.bit_idx = s_q.bit_idx + 1'b1;
                            s_d.phase   = PH_BIT_MARK;
                            s_d.left    = T_BIT_MARK;
                        end
                    end
                    PH_STOP_MARK: begin
                        s_d.phase = PH_IDLE;
                        s_d.left  = '0;
                    end
                    default: begin
                        s_d.phase = PH_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign take_o      = take;
    assign rep_start_o = take && rep_now;
    assign txd_o       = s_q.txd;

    p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |-> !txd_o)
        else $error("output active while idle");

    p_moves_only_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(txd_o))
        else $error("output changed without a carrier tick");

    p_space_is_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_LEAD_SPACE || s_q.phase == PH_BIT_SPACE) && tick_i && !take)
            |=> !txd_o)
        else $error("output high during a space");

    p_no_bits_in_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rep |-> (s_q.phase != PH_BIT_MARK && s_q.phase != PH_BIT_SPACE))
        else $error("repeat code entered the data bits");

endmodule

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
    parameter int UNIT_TICKS   = 42,
    parameter int WINDOW_UNITS = 192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic        busy_o,
    input  logic        carrier_tick_i,
    output logic        txd_o
);

    localparam int MSG_W       = 32;
    localparam int LIMIT_TICKS = WINDOW_UNITS * UNIT_TICKS;

    logic             take;
    logic             rep_start;
    logic             win_open;
    logic             busy;
    logic [MSG_W-1:0] held_word;

    nec_tx_hold #(.MSG_W(MSG_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en_i),
        .data_i (wr_data_i),
        .take_i (take),
        .busy_o (busy),
        .word_o (held_word)
    );

    nec_tx_window #(.LIMIT_TICKS(LIMIT_TICKS)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (carrier_tick_i),
        .restart_i (take),
        .open_o    (win_open)
    );

    nec_tx_seq #(.MSG_W(MSG_W), .UNIT_TICKS(UNIT_TICKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (carrier_tick_i),
        .pend_i      (busy),
        .word_i      (held_word),
        .win_open_i  (win_open),
        .take_o      (take),
        .rep_start_o (rep_start),
        .txd_o       (txd_o)
    );

    assign busy_o = busy;

    p_repeat_needs_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rep_start |-> win_open)
        else $error("repeat started with the window closed");

    p_take_needs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> busy_o)
        else $error("transfer without a pending word");

endmodule

// File: tb/tb_nec_ir_tx.sv
`timescale 1ns/1ps
module tb_nec_ir_tx;

    localparam int UT  = 2;
    localparam int WIN = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        tick = 1'b0;
    logic        busy;
    logic        txd;

    int errs = 0;
    int checks = 0;

    int ph_u [0:69];
    bit ph_m [0:69];
    int nph;

    nec_ir_tx #(.UNIT_TICKS(UT), .WINDOW_UNITS(WIN)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr),
        .wr_data_i      (wdata),
        .busy_o         (busy),
        .carrier_tick_i (tick),
        .txd_o          (txd)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected frame model, built in units
    task automatic build(input bit rep, input logic [31:0] w);
        nph = 0;
        ph_u[nph] = 16; ph_m[nph] = 1; nph++;
        ph_u[nph] = rep ? 4 : 8; ph_m[nph] = 0; nph++;
        if (!rep) begin
            for (int b = 0; b < 32; b++) begin
                ph_u[nph] = 1; ph_m[nph] = 1; nph++;
                ph_u[nph] = w[b] ? 3 : 1; ph_m[nph] = 0; nph++;
            end
        end
        ph_u[nph] = 1; ph_m[nph] = 1; nph++;
    endtask

    function automatic int total_ticks();
        int t = 0;
        for (int i = 0; i < nph; i++) t += ph_u[i] * UT;
        return t;
    endfunction

    function automatic bit level(input int k);
        int base = 0;
        for (int i = 0; i < nph; i++) begin
            if (k < base + ph_u[i] * UT)
                return ph_m[i] ? ((k - base) % 2 == 0) : 1'b0;
            base += ph_u[i] * UT;
        end
        return 1'b0;
    endfunction

    task automatic wait_tick();
        do @(posedge clk); while (!tick);
        @(negedge clk);
    endtask

    // Write while idle: busy rises, then drops one cycle later
    task automatic write_idle(input logic [31:0] w);
        @(negedge clk);
        wr = 1'b1; wdata = w;
        @(negedge clk);
        wr = 1'b0;
        chk(busy === 1'b1, "R1", "busy after write", busy, 1);
        @(negedge clk);
        chk(busy === 1'b0, "R2", "busy after transfer", busy, 0);
    endtask

    task automatic gap(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            wait_tick();
            if (txd !== 1'b0) bad++;
        end
        chk(bad == 0, req, "txd low between frames", bad, 0);
    endtask

    task automatic check_frame(input logic [31:0] w, input bit rep, input string req,
                               input int inj1, input logic [31:0] w1,
                               input int inj2, input logic [31:0] w2);
        int waited = 0;
        int mism = 0;
        int first_k = -1;
        int tot;
        build(rep, w);
        tot = total_ticks();
        do begin
            wait_tick();
            waited++;
        end while (txd !== 1'b1 && waited < 2000);
        chk(waited < 2000, req, "frame start seen", waited, 1);
        for (int k = 0; k < tot; k++) begin
            if (k > 0) wait_tick();
            if (txd !== level(k)) begin
                mism++;
                if (first_k < 0) first_k = k;
            end
            if (k == inj1 || k == inj2) begin
                wr = 1'b1;
                wdata = (k == inj1) ? w1 : w2;
                @(negedge clk);
                wr = 1'b0;
                chk(busy === 1'b1, "R3", "busy while queued", busy, 1);
            end
        end
        chk(mism == 0, req, rep ? "repeat code waveform (first bad tick)" :
            "full frame waveform (first bad tick)", first_k, -1);
        if (inj1 >= 0)
            chk(busy === 1'b1, "R3", "busy held until frame end", busy, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] last;
        logic [31:0] w;
        bit same, short_gap;
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R8", "busy after reset", busy, 0);
        chk(txd === 1'b0, "R8", "txd after reset", txd, 0);
        gap(10, "R8");

        // First word after reset is a full frame even though it is zero
        write_idle(32'h0000_0000);
        check_frame(32'h0000_0000, 1'b0, "R8", -1, '0, -1, '0);
        gap(420, "R5");

        // Full frame; the same word queued mid-frame becomes a repeat
        write_idle(32'h619E_5CA3);
        check_frame(32'h619E_5CA3, 1'b0, "R4", 20, 32'h619E_5CA3, -1, '0);
        check_frame(32'h619E_5CA3, 1'b1, "R6", -1, '0, -1, '0);

        // Window restarted by the repeat: still open after the full frame's has passed
        gap(150, "R5");
        write_idle(32'h619E_5CA3);
        check_frame(32'h619E_5CA3, 1'b1, "R7", -1, '0, -1, '0);

        // Window expired: same word sends a full frame
        gap(420, "R5");
        write_idle(32'h619E_5CA3);
        check_frame(32'h619E_5CA3, 1'b0, "R7", -1, '0, -1, '0);

        // Different word inside the window: full frame
        gap(5, "R5");
        write_idle(32'hEE11_FF00);
        check_frame(32'hEE11_FF00, 1'b0, "R7", 10, 32'h1234_5678, 30, 32'hB44B_02FD);
        // Only the last queued word goes out
        check_frame(32'hB44B_02FD, 1'b0, "R3", -1, '0, -1, '0);
        last = 32'hB44B_02FD;

        // Random mix of repeats and fresh words
        for (int i = 0; i < 14; i++) begin
            same      = $urandom % 2;
            short_gap = $urandom % 2;
            if (same) begin
                w = last;
            end else begin
                w = $urandom;
                if (w == last) w = ~last;
            end
            gap(short_gap ? 1 + ($urandom % 20) : 420 + ($urandom % 60), "R5");
            write_idle(w);
            check_frame(w, same && short_gap, (same && short_gap) ? "R6" : "R4",
                        -1, '0, -1, '0);
            last = w;
        end

        gap(4, "R5");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule